// File: doc/BRIEF.md
# Trinary Serial Remote Encoder

This block turns nine three-state inputs into a serial pulse stream of the kind used by simple remote-control links. It works out each input's state with a digital version of the weak-drive test. A pull-direction output first asks the pad logic for a weak pull-down, and the pin is sampled. The output then asks for a weak pull-up, and the pin is sampled again. A pin that follows both pulls is open. A pin that holds its level under both pulls is a hard 0 or a hard 1.

Each input becomes one data bit of two pulses, and every pulse is short or long. Zero is short-short, one is long-long, and open is long then short. Nine bits make a word. Every start produces two identical words with a silent gap between them. The sequencer advances only on cycles where the enable tick is high, so the tick sets the transmit bit rate. The transmit request is active low. It is sampled only at the start of a pair and at the last tick of the second word. The block has no data stream at its edge: the request, the tick, the pins and the serial output are plain level signals, with no valid/ready handshake and no back-pressure.

Top module: `trinary_tx_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, `ser_out` and `pull_up` are both low.
- R2: For each bit, classification uses the four ticks just before that bit's first pulse. `pull_up` is low for the first two of these ticks and high for the last two. The pin is sampled at the 2nd tick (pull-down applied) and at the 4th tick (pull-up applied).
- R3: A data bit lasts 8 ticks, split into two 4-tick slots. A short pulse is high for the first 1 tick of its slot and a long pulse is high for the first 3 ticks. Symbol 0 sends short,short; symbol 1 sends long,long; open sends long,short.
- R4: With the block idle, a tick while `tx_en_n` is low starts a pair. There are 4 lead-in ticks with the output low. Then pins 0 to 8 are sent in index order, pin 0 first, which gives 36 pulses per pair.
- R5: Between the two words of a pair, and between consecutive pairs, `ser_out` stays low for 24 ticks (three bit times).
- R6: A started pair always completes both words, whatever `tx_en_n` does while it runs.
- R7: `tx_en_n` is sampled at the last tick of each second word. If it is low, a 24-tick gap follows and then a new pair. If it is high, the block goes idle.
- R8: On cycles where `tick` is low, neither output changes.
- R9: While idle, `ser_out` and `pull_up` stay low, whatever the pins and the ticks do.
- R10: A pin's symbol is latched at its 4th classification tick. Later pin changes do not alter a bit that has already been latched.
- R11: The classification is as follows. High under both pulls gives 1. Low under both pulls gives 0. Any other pair of readings is open, including a pin that reads high under pull-down and low under pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Enable; the sequencer advances only when high |
| tx_en_n | input | 1 | Active-low transmit request |
| pin_in | input | PINS (9) | Sampled levels of the three-state input pins |
| pull_up | output | 1 | Pull direction for the pad: 1 = weak pull-up, 0 = weak pull-down |
| ser_out | output | 1 | Serial pulse stream |

## Verification
The bench uses the default parameters: nine pins, 4-tick slots, 1-tick and 3-tick pulses, and a gap of three bits. A whole pair then lasts 172 ticks, so single pairs, held requests that run several pairs back to back, and requests released partway through a pair all fit in a short run. The pin model has a fourth mode that drives each pin against the pull, which covers the crossed-reading case of R11. Random gaps in the tick stream and pin changes made during transmission reach R8 and R10.

// File: rtl/trinary_tx_pkg.sv
package trinary_tx_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_OPEN = 2'd2
  } sym_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/trit_tx_seq.sv
module trit_tx_seq
  import trinary_tx_pkg::*;
#(
  parameter int PINS       = 9,
  parameter int SLOT_TICKS = 4,
  parameter int GAP_BITS   = 3,
  localparam int BIT_TICKS = 2 * SLOT_TICKS,
  localparam int PH_W      = $clog2(BIT_TICKS),
  localparam int IDX_W     = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tx_en_n,
  output seq_st_t          st,
  output logic [PH_W-1:0]  phase,
  output logic             word,
  output logic [IDX_W-1:0] cls_idx,
  output logic             lo_stb,
  output logic             hi_stb,
  output logic             pull_up
);
  localparam int GAP_W = $clog2(GAP_BITS + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_TICKS - 1);
  localparam logic [PH_W-1:0]  PH_LEAD = PH_W'(BIT_TICKS - 4);
  localparam logic [PH_W-1:0]  PH_LO   = PH_W'(BIT_TICKS - 3);
  localparam logic [PH_W-1:0]  PH_PU   = PH_W'(BIT_TICKS - 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PINS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);

  logic [IDX_W-1:0] bit_idx;
  logic [GAP_W-1:0] gap_cnt;
  logic             cls_en;

  // a classification window is open when a data bit follows the current bit time
  always_comb begin
    cls_en  = (st == ST_LEAD) ||
              (st == ST_DATA && bit_idx != IDX_LAST) ||
              (st == ST_GAP  && gap_cnt == GAP_LAST);
    cls_idx = (st == ST_DATA) ? bit_idx + IDX_W'(1) : '0;
    pull_up = cls_en && (phase >= PH_PU);
    lo_stb  = tick && cls_en && (phase == PH_LO);
    hi_stb  = tick && cls_en && (phase == PH_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      phase   <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
      word    <= 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE: begin
          if (!tx_en_n) begin
            st      <= ST_LEAD;
            phase   <= PH_LEAD;
            bit_idx <= '0;
            gap_cnt <= '0;
            word    <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (phase == PH_LAST) begin
            st    <= ST_DATA;
            phase <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_DATA: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            if (bit_idx == IDX_LAST) begin
              bit_idx <= '0;
              gap_cnt <= '0;
              if (!word) begin
                st   <= ST_GAP;
                word <= 1'b1;
              end else if (!tx_en_n) begin
                st   <= ST_GAP;
                word <= 1'b0;
              end else begin
                st   <= ST_IDLE;
                word <= 1'b0;
              end
            end else begin
              bit_idx <= bit_idx + IDX_W'(1);
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_GAP: begin
          if (phase == PH_LAST) begin
            phase <= '0;
            if (gap_cnt == GAP_LAST) begin
              st      <= ST_DATA;
              gap_cnt <= '0;
            end else begin
              gap_cnt <= gap_cnt + GAP_W'(1);
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trit_tx_classify.sv
module trit_tx_classify
  import trinary_tx_pkg::*;
#(
  parameter int PINS = 9,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pin_in,
  input  logic [IDX_W-1:0] cls_idx,
  input  logic             lo_stb,
  input  logic             hi_stb,
  output sym_t             sym
);
  logic pin_sel;
  logic lo_q;

  always_comb begin
    pin_sel = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      if (cls_idx == IDX_W'(i)) pin_sel = pin_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      sym  <= SYM_ZERO;
    end else begin
      if (lo_stb) lo_q <= pin_sel;
      if (hi_stb) begin
        if (lo_q && pin_sel)        sym <= SYM_ONE;
        else if (!lo_q && !pin_sel) sym <= SYM_ZERO;
        else                        sym <= SYM_OPEN;
      end
    end
  end
endmodule

// File: rtl/trit_tx_pulse.sv
module trit_tx_pulse
  import trinary_tx_pkg::*;
#(
  parameter int SLOT_TICKS = 4,
  parameter int SHORT_HI   = 1,
  parameter int LONG_HI    = 3,
  localparam int PH_W      = $clog2(2 * SLOT_TICKS)
) (
  input  logic            in_data,
  input  logic [PH_W-1:0] phase,
  input  sym_t            sym,
  output logic            ser_out
);
  localparam logic [PH_W-1:0] SLOT_W  = PH_W'(SLOT_TICKS);
  localparam logic [PH_W-1:0] SHORT_W = PH_W'(SHORT_HI);
  localparam logic [PH_W-1:0] LONG_W  = PH_W'(LONG_HI);

  logic            second;
  logic [PH_W-1:0] sub;
  logic            is_long;

  always_comb begin
    second  = (phase >= SLOT_W);
    sub     = second ? phase - SLOT_W : phase;
    is_long = second ? (sym == SYM_ONE) : (sym != SYM_ZERO);
    ser_out = in_data && (sub < (is_long ? LONG_W : SHORT_W));
  end
endmodule

// File: rtl/trinary_tx_encoder.sv
module trinary_tx_encoder
  import trinary_tx_pkg::*;
#(
  parameter int PINS       = 9,
  parameter int SLOT_TICKS = 4,
  parameter int SHORT_HI   = 1,
  parameter int LONG_HI    = 3,
  parameter int GAP_BITS   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            tx_en_n,
  input  logic [PINS-1:0] pin_in,
  output logic            pull_up,
  output logic            ser_out
);
  localparam int PH_W  = $clog2(2 * SLOT_TICKS);
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1;

  seq_st_t          seq_st;
  logic [PH_W-1:0]  seq_phase;
  logic             seq_word;
  logic [IDX_W-1:0] cls_idx;
  logic             lo_stb;
  logic             hi_stb;
  sym_t             sym;

  trit_tx_seq #(.PINS(PINS), .SLOT_TICKS(SLOT_TICKS), .GAP_BITS(GAP_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en_n(tx_en_n),
    .st(seq_st), .phase(seq_phase), .word(seq_word), .cls_idx(cls_idx),
    .lo_stb(lo_stb), .hi_stb(hi_stb), .pull_up(pull_up)
  );

  trit_tx_classify #(.PINS(PINS)) u_cls (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cls_idx(cls_idx),
    .lo_stb(lo_stb), .hi_stb(hi_stb), .sym(sym)
  );

  trit_tx_pulse #(.SLOT_TICKS(SLOT_TICKS), .SHORT_HI(SHORT_HI), .LONG_HI(LONG_HI)) u_pulse (
    .in_data(seq_st == ST_DATA), .phase(seq_phase), .sym(sym), .ser_out(ser_out)
  );
endmodule

// File: rtl/trinary_tx_encoder_chk.sv
module trinary_tx_encoder_chk
  import trinary_tx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    tick,
  input logic    ser_out,
  input logic    pull_up,
  input seq_st_t st,
  input logic    word
);
  // R8
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ser_out) && $stable(pull_up)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!ser_out && !pull_up));

  // R5
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> !ser_out);

  // R4
  pulse_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out |-> (st == ST_DATA));

  // R6
  pair_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == ST_DATA && !word) |=> (st != ST_IDLE));

  // R2
  pull_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_up) |-> $past(tick));
endmodule

bind trinary_tx_encoder trinary_tx_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ser_out(ser_out),
  .pull_up(pull_up), .st(seq_st), .word(seq_word)
);

// File: tb/trinary_tx_encoder_bench.sv
module trinary_tx_encoder_bench;
  localparam int NP = 9;
  localparam int LEAD = 4;
  localparam int DATA_T = 72;
  localparam int WORDP = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic tx_en_n = 1'b1;
  logic [NP-1:0] pin_in;
  logic pull_up, ser_out;

  // pin modes: 0 tied low, 1 tied high, 2 open (follows pull), 3 fights pull (R11)
  logic [1:0] pin_mode [NP];
  int errors = 0, checks = 0;
  bit tick_rand = 0, done = 0;
  int rise_cnt = 0;
  logic prev_ser = 1'b0;

  int m_act = 0, m_t = 0;
  int sym_exp [NP];
  int lo_cap [NP];

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      case (pin_mode[i])
        2'd0: pin_in[i] = 1'b0;
        2'd1: pin_in[i] = 1'b1;
        2'd2: pin_in[i] = pull_up;
        default: pin_in[i] = ~pull_up;
      endcase
    end
  end

  trinary_tx_encoder u_trinary_tx_encoder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en_n(tx_en_n),
    .pin_in(pin_in), .pull_up(pull_up), .ser_out(ser_out)
  );

  // start tick of the data bit whose classification window contains t
  function automatic void next_bit(input int t, output int s, output int k);
    int pos, w, r;
    if (t < LEAD) begin s = LEAD; k = 0; end
    else begin
      pos = t - LEAD; w = pos / WORDP; r = pos % WORDP;
      if (r < DATA_T && r / 8 < NP - 1) begin k = r / 8 + 1; s = LEAD + w * WORDP + 8 * k; end
      else begin k = 0; s = LEAD + (w + 1) * WORDP; end
    end
  endfunction

  // behavioural reference, advanced on each ticked edge
  always @(posedge clk) begin
    int s, k, pos;
    if (!rst_n) begin
      m_act = 0; m_t = 0;
    end else if (tick) begin
      if (m_act == 0) begin
        if (!tx_en_n) begin m_act = 1; m_t = 0; end
      end else begin
        next_bit(m_t, s, k);
        if (s - m_t == 3) lo_cap[k] = (pin_mode[k] == 2'd1 || pin_mode[k] == 2'd3) ? 1 : 0;
        if (s - m_t == 1) begin
          int hi;
          hi = (pin_mode[k] == 2'd1 || pin_mode[k] == 2'd2) ? 1 : 0;
          sym_exp[k] = (lo_cap[k] == 1 && hi == 1) ? 1 : (lo_cap[k] == 0 && hi == 0) ? 0 : 2;
        end
        pos = m_t - LEAD;
        if (m_t >= LEAD && pos % WORDP == DATA_T - 1 && (pos / WORDP) % 2 == 1 && tx_en_n)
          m_act = 0;
        else
          m_t = m_t + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    int es, ep, pos, r, k, p, wd;
    string tag;
    if (rst_n && !done) begin
      es = 0; ep = 0; tag = "R9 idle";
      if (m_act != 0) begin
        if (m_t < LEAD) begin ep = (m_t >= 2) ? 1 : 0; tag = "R4 lead"; end
        else begin
          pos = m_t - LEAD; r = pos % WORDP;
          if (r < DATA_T) begin
            k = r / 8; p = r % 8;
            wd = ((p < 4) ? (sym_exp[k] != 0) : (sym_exp[k] == 1)) ? 3 : 1;
            es = ((p % 4) < wd) ? 1 : 0;
            ep = (k < NP - 1 && p >= 6) ? 1 : 0;
            tag = "R3 R10 R11 data";
          end else begin
            ep = (r >= WORDP - 2) ? 1 : 0;
            tag = "R5 R7 gap";
          end
        end
      end
      check(ser_out == es[0], tag, ser_out, es);
      check(pull_up == ep[0], "R2 pull", pull_up, ep);
    end
    if (ser_out && !prev_ser) rise_cnt++;
    prev_ser <= ser_out;
  end

  // R8: gaps in the tick stream
  always @(negedge clk) tick <= tick_rand ? (($urandom % 4) != 0) : 1'b1;

  task automatic set_all(input logic [1:0] m);
    for (int i = 0; i < NP; i++) pin_mode[i] = m;
  endtask

  task automatic one_pair(input int hold);
    rise_cnt = 0;
    @(negedge clk) tx_en_n = 1'b0;
    repeat (hold) @(negedge clk);
    tx_en_n = 1'b1;
    repeat (400) @(negedge clk);
    check(rise_cnt == 36, "R4 R6 pulses per pair", rise_cnt, 36);
  endtask

  initial begin
    set_all(2'd0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ser_out == 1'b0, "R1 ser_out in reset", ser_out, 0);
    check(pull_up == 1'b0, "R1 pull_up in reset", pull_up, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b0 && pull_up == 1'b0, "R1 after reset", {ser_out, pull_up}, 0);

    // R9: pins move while idle
    for (int n = 0; n < 40; n++) begin
      pin_mode[n % NP] = 2'($urandom % 4);
      @(negedge clk);
    end

    // mixed pattern, short request: one pair only (R6)
    pin_mode[0] = 2'd0; pin_mode[1] = 2'd1; pin_mode[2] = 2'd2;
    pin_mode[3] = 2'd3; pin_mode[4] = 2'd2; pin_mode[5] = 2'd1;
    pin_mode[6] = 2'd0; pin_mode[7] = 2'd2; pin_mode[8] = 2'd1;
    one_pair(3);
    // request released in the middle of the first word (R6)
    one_pair(60);

    set_all(2'd0); one_pair(2);
    set_all(2'd1); one_pair(2);
    set_all(2'd2); one_pair(2);
    set_all(2'd3); one_pair(2);

    // R7 R8 R10: held request, gapped ticks, pins changing in flight
    tick_rand = 1;
    @(negedge clk) tx_en_n = 1'b0;
    for (int n = 0; n < 700; n++) begin
      @(negedge clk);
      if (n % 7 == 0) pin_mode[$urandom % NP] = 2'($urandom % 4);
    end
    tx_en_n = 1'b1;
    repeat (600) @(negedge clk);
    check(ser_out == 1'b0 && pull_up == 1'b0, "R7 idle after release", {ser_out, pull_up}, 0);
    tick_rand = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule